// File: doc/BRIEF.md
# Matrix keypad scanning encoder

The block scans a switch matrix built from four column drive lines and four or five row sense lines, giving 16 or 20 keys. It pulls one column low at a time in rotating order and watches the active-low rows, which are pulled up outside the block. When a row reads low, the column stays frozen and the closure is debounced over a programmable number of clock cycles. Once the key has been held for that whole period, the block turns the key position into a 5-bit binary code, stores it in a last-key register and raises the key-ready flag.

When the accepted key is released, the key-ready flag drops, even if another key is still down. A key that is still held is then picked up by the scan and accepted after a fresh debounce period. This gives two-key roll-over between any pair of switches. The stored code stays on the outputs after release, until a new key is accepted. An output-enable input models a three-state data bus: when it is low, the data lines read zero and the valid flag is low. It has no effect on scanning, debouncing or the key-ready flag. A bypass input skips the debounce wait.

Top module: `keypad_encoder`

## Requirements
- R1: Exactly one bit of `col_n` is low in every cycle. After reset, column 0 is driven (`col_n` = 4'b1110). With no row low, the driven column advances by one each cycle, wrapping from 3 to 0, and it stays frozen while a detected key is being debounced or held.
- R2: A key at row r (0..3) and column c (0..3) is coded as 4·r + c, with bit 0 as the least significant bit and bit 4 = 0.
- R3: A key on the fifth row (row index 4, `NUM_ROWS` = 5) is coded with bit 4 = 1, bits 3:2 = 0 and bits 1:0 = column index (codes 16..19).
- R4: With `db_bypass` low, `avail` rises only after the key has read low for `DEBOUNCE_CYCLES` consecutive scan-frozen cycles. A row reading high during the count restarts the debounce.
- R5: `avail` falls on the first clock edge at which the accepted key's row reads high, even if another key is still closed.
- R6: After such a release, a key that is still held is accepted, and `avail` rises again only after a full debounce period, with that key's code.
- R7: The code register is loaded only at the edge where `avail` rises. It keeps its value while the key is held, when other keys are pressed meanwhile, and after release.
- R8: With `oe` low, `code` reads 0 and `code_vld` is low, while `avail` and the stored code are unaffected. With `oe` high, `code` shows the register and `code_vld` is high.
- R9: With `db_bypass` high, a detected closure is accepted on the same edge that finds it.
- R10: Reset (`rst_n` low) clears `avail` and the code register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan and debounce clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n | input | NUM_ROWS | Row sense lines, low when a switch on the driven column is closed |
| oe | input | 1 | Output enable for the code bus |
| db_bypass | input | 1 | Skip the debounce wait when high |
| col_n | output | 4 | Column drive, one line low at a time |
| code | output | 5 | Last accepted key code, zero when disabled |
| code_vld | output | 1 | High when the code bus is driven |
| avail | output | 1 | Key-ready flag with two-key roll-over |

## Verification
All results come from one register stage. A row change driven at a falling edge is seen at the next rising edge, so a release makes `avail` fall one cycle later, and a bypassed key is accepted within one to four cycles, depending on where the scan stands. A debounced key raises `avail` between `DEBOUNCE_CYCLES`+1 and `DEBOUNCE_CYCLES`+4 cycles after the press. The bench samples every output at the falling edge and checks that count against that window, counting from the press or from the last bounce. The `oe` gating is combinational, so it is checked half a cycle after `oe` changes.

// File: rtl/kpe_pkg.sv
package kpe_pkg;

    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HOLD   = 2'd2
    } kpe_state_e;

    // Row 0..3: code = 4*row + col, bit 4 clear. Row 4: bit 4 set, column in bits 1:0.
    function automatic logic [4:0] kpe_encode(input logic [2:0] row, input logic [1:0] col);
        if (row == 3'd4) return {1'b1, 2'b00, col};
        return {1'b0, row[1:0], col};
    endfunction

endpackage

// File: rtl/kpe_col_drive.sv
module kpe_col_drive #(
    parameter int NUM_COLS = 4,
    localparam int COL_W = $clog2(NUM_COLS)
) (
    input  logic [COL_W-1:0]    col,
    output logic [NUM_COLS-1:0] col_n
);
    for (genvar g = 0; g < NUM_COLS; g++) begin : g_col
        assign col_n[g] = (col != COL_W'(g));
    end
endmodule

// File: rtl/kpe_row_pick.sv
module kpe_row_pick #(
    parameter int NUM_ROWS = 5
) (
    input  logic [NUM_ROWS-1:0] row_n,
    output logic                any_low,
    output logic [2:0]          low_idx
);
    always_comb begin
        low_idx = 3'd0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (!row_n[i]) low_idx = 3'(i);
        end
        any_low = ~&row_n;
    end
endmodule

// File: rtl/keypad_encoder.sv
module keypad_encoder #(
    parameter int NUM_ROWS        = 5,
    parameter int DEBOUNCE_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_n,
    input  logic                oe,
    input  logic                db_bypass,
    output logic [3:0]          col_n,
    output logic [4:0]          code,
    output logic                code_vld,
    output logic                avail
);
    import kpe_pkg::*;

    localparam int NUM_COLS = 4;
    localparam int COL_W    = $clog2(NUM_COLS);
    localparam int CNT_W    = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        kpe_state_e       st;
        logic [COL_W-1:0] col;
        logic [2:0]       row;
        logic [CNT_W-1:0] cnt;
        logic [4:0]       code;
        logic             avail;
    } regs_t;

    regs_t r_q, r_d;

    logic       any_low;
    logic [2:0] low_idx;
    logic [7:0] row_low_ext;
    logic       row_held;

    kpe_row_pick #(.NUM_ROWS(NUM_ROWS)) u_pick (
        .row_n   (row_n),
        .any_low (any_low),
        .low_idx (low_idx)
    );

    kpe_col_drive #(.NUM_COLS(NUM_COLS)) u_drive (
        .col   (r_q.col),
        .col_n (col_n)
    );

    assign row_low_ext = 8'(~row_n);
    assign row_held    = row_low_ext[r_q.row];

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_SCAN: begin
                if (any_low) begin
                    r_d.row = low_idx;
                    r_d.cnt = '0;
                    if (db_bypass) begin
                        r_d.st    = ST_HOLD;
                        r_d.code  = kpe_encode(low_idx, r_q.col);
                        r_d.avail = 1'b1;
                    end else begin
                        r_d.st = ST_SETTLE;
                    end
                end else begin
                    r_d.col = r_q.col + COL_W'(1);
                end
            end
            ST_SETTLE: begin
                if (!row_held) begin
                    r_d.st = ST_SCAN;
                end else if (r_q.cnt == CNT_LAST || db_bypass) begin
                    r_d.st    = ST_HOLD;
                    r_d.code  = kpe_encode(r_q.row, r_q.col);
                    r_d.avail = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (!row_held) begin
                    r_d.st    = ST_SCAN;
                    r_d.avail = 1'b0;
                end
            end
            default: r_d.st = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_SCAN, col: '0, row: '0, cnt: '0, code: '0, avail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign avail    = r_q.avail;
    assign code_vld = oe;
    assign code     = oe ? r_q.code : 5'd0;

endmodule

// File: rtl/kpe_checker.sv
module kpe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       oe,
    input logic [3:0] col_n,
    input logic [4:0] code,
    input logic       code_vld,
    input logic       avail
);
    AST_ONE_COLUMN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_n) == 1);                                         // R1

    AST_COLUMN_FROZEN_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && $past(avail)) |-> $stable(col_n));                      // R1

    AST_FIFTH_ROW_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        code[4] |-> (code[3:2] == 2'b00));                                // R3

    AST_CODE_HELD_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && $past(avail) && oe && $past(oe)) |-> $stable(code));     // R7

    AST_BUS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (code == 5'd0 && !code_vld));                             // R8
endmodule

bind keypad_encoder kpe_checker u_kpe_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe       (oe),
    .col_n    (col_n),
    .code     (code),
    .code_vld (code_vld),
    .avail    (avail)
);

// File: tb/sim_keypad_encoder.sv
module sim_keypad_encoder;
    localparam int ROWS = 5;
    localparam int DEB  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ROWS-1:0] row_n;
    logic            oe = 1'b1;
    logic            db_bypass = 1'b0;
    logic [3:0]      col_n;
    logic [4:0]      code;
    logic            code_vld;
    logic            avail;
    logic [19:0]     keys = '0;

    int total = 0;
    int failed = 0;

    always #4 clk = ~clk;

    // Keypad model: a closed key pulls its row low while its column is driven low.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 4; c++)
                if (keys[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
        end
    end

    keypad_encoder #(.NUM_ROWS(ROWS), .DEBOUNCE_CYCLES(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .oe(oe), .db_bypass(db_bypass),
        .col_n(col_n), .code(code), .code_vld(code_vld), .avail(avail)
    );

    // key index, expected code
    localparam logic [9:0] VEC [10] = '{
        {5'd0,  5'd0},  {5'd3,  5'd3},  {5'd4,  5'd4},  {5'd7,  5'd7},
        {5'd10, 5'd10}, {5'd13, 5'd13}, {5'd15, 5'd15}, {5'd16, 5'b10000},
        {5'd18, 5'b10010}, {5'd19, 5'b10011}
    };

    task automatic check(input string req, input logic ok, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!avail && n < 4 * DEB + 20);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        int n;
        logic [4:0] prev;
        repeat (3) @(negedge clk);
        check("R10 avail", avail == 1'b0, avail, 0);
        check("R10 code", code == 5'd0, code, 0);
        rst_n = 1'b1;
        check("R1 first column", col_n == 4'b1110, col_n, 4'b1110);
        @(negedge clk);
        check("R1 rotate 1", col_n == 4'b1101, col_n, 4'b1101);
        @(negedge clk);
        check("R1 rotate 2", col_n == 4'b1011, col_n, 4'b1011);
        @(negedge clk);
        check("R1 rotate 3", col_n == 4'b0111, col_n, 4'b0111);
        @(negedge clk);
        check("R1 wrap", col_n == 4'b1110, col_n, 4'b1110);

        // Vector table: press, time the debounce, check the code, release.
        foreach (VEC[i]) begin
            keys[VEC[i][9:5]] = 1'b1;
            wait_ready(n);
            check("R4 debounce window", n >= DEB + 1 && n <= DEB + 4, n, DEB + 1);
            check(VEC[i][9:5] >= 16 ? "R3 code" : "R2 code", code == VEC[i][4:0], code, VEC[i][4:0]);
            keys = '0;
            @(negedge clk);
            check("R5 release", avail == 1'b0, avail, 0);
            check("R7 persists", code == VEC[i][4:0], code, VEC[i][4:0]);
            repeat (2) @(negedge clk);
        end

        // Bounce restarts the debounce count.
        keys[2] = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 not early", avail == 1'b0, avail, 0);
        keys[2] = 1'b0;
        @(negedge clk);
        keys[2] = 1'b1;
        wait_ready(n);
        check("R4 restart", n >= DEB + 1 && n <= DEB + 4, n, DEB + 1);

        // Output enable gating while held.
        oe = 1'b0;
        #1;
        check("R8 code zero", code == 5'd0, code, 0);
        check("R8 vld low", code_vld == 1'b0, code_vld, 0);
        @(negedge clk);
        check("R8 avail kept", avail == 1'b1, avail, 1);
        oe = 1'b1;
        #1;
        check("R8 restored", code == 5'd2 && code_vld, code, 2);
        keys = '0;
        repeat (3) @(negedge clk);

        // Two-key roll-over.
        keys[1] = 1'b1;
        wait_ready(n);
        check("R2 first key", code == 5'd1, code, 1);
        keys[6] = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 second ignored", code == 5'd1 && avail, code, 1);
        keys[1] = 1'b0;
        @(negedge clk);
        check("R5 drop with second held", avail == 1'b0, avail, 0);
        check("R7 kept after drop", code == 5'd1, code, 1);
        wait_ready(n);
        check("R6 fresh debounce", n >= DEB + 1 && n <= DEB + 4, n, DEB + 1);
        check("R6 second code", code == 5'd6, code, 6);
        keys = '0;
        repeat (3) @(negedge clk);

        // Debounce bypass.
        db_bypass = 1'b1;
        keys[9] = 1'b1;
        wait_ready(n);
        check("R9 immediate", n >= 1 && n <= 4, n, 1);
        check("R9 code", code == 5'd9, code, 9);
        keys = '0;
        @(negedge clk);
        db_bypass = 1'b0;
        prev = code;
        repeat (2) @(negedge clk);
        check("R7 idle persist", code == prev && !avail, code, prev);

        // Reset clears the register.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 code cleared", code == 5'd0 && !avail, code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule